// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the general register file of a processor core that gives each procedure its own window of registers. The storage holds 74 physical 32-bit registers. A core always sees 32 logical registers, numbered 0 to 31. A window pointer decides which physical registers sit behind those logical numbers. Logical 0 to 9 are global: they reach the same ten physical registers from every window. Logical 10 to 31 reach a slice of a 64-register circular region. Within that slice, 10 to 15 are the low shared set, 16 to 25 are locals and 26 to 31 are the high shared set. The slice for window `w` starts 16 registers further on than the slice for window `w-1`. Because of this, the high shared set of a caller is the same storage as the low shared set of the procedure it calls. Arguments and results therefore pass between them without any copying.

The block has two combinational read ports and one write port that writes on the clock edge. All three are addressed by logical number, and the translation to a physical index happens inside the block. A call strobe moves the window pointer forward by one, and a return strobe moves it back by one, both modulo four. A counter tracks how many windows currently hold live procedure state. The block flags overflow when a call arrives with every window in use, and underflow when a return arrives with only one window in use. Spilling and refilling windows in memory is left to the logic around the block.

Top module: `regwin_file`

## Requirements
- R1: After a synchronous active-low reset, every logical register reads 0 in every window, `cwp_o` is 0, and neither flag is raised.
- R2: Logical registers 0 to 9 return the same storage whatever the window pointer is.
- R3: A write becomes visible on the clock edge. A read of the register being written in that same cycle returns the value it held before the write.
- R4: A call alone (`call_i`=1, `ret_i`=0) advances `cwp_o` by one modulo 4 at the clock edge. A return alone decrements it by one modulo 4.
- R5: After a call, the callee's logical 10 to 15 are the caller's logical 26 to 31, in the same order.
- R6: Logical 16 to 25 are private to each window. Writing one of them in one window leaves the same logical register of every other window unchanged.
- R7: The windows wrap: logical 26 to 31 in window 3 are logical 10 to 15 in window 0.
- R8: The two read ports are independent. Each returns the register its own address selects, in the same cycle.
- R9: `ovf_o` is 1 during a call cycle exactly when all 4 windows are in use. The pointer still advances, and the count of windows in use stays at 4.
- R10: `unf_o` is 1 during a return cycle exactly when only one window is in use. The pointer still moves back, and the count stays at 1.
- R11: When `call_i` and `ret_i` are both 1 in the same cycle, neither takes effect: `cwp_o` and the count of windows in use do not change, and no flag is raised.
- R12: A write in the same cycle as a call or a return goes to the window that was current before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 5 | Logical register number for read port A |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Logical register number for read port B |
| rd_data_b | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Call strobe: advance window |
| ret_i | input | 1 | Return strobe: retreat window |
| cwp_o | output | 2 | Current window pointer |
| ovf_o | output | 1 | Window overflow on this call |
| unf_o | output | 1 | Window underflow on this return |

## Verification
The bench drives the pointer all the way round the ring in both directions. It does so to catch a mapping that forgets the wrap, which would send window 3's high shared set past the end of storage instead of onto window 0's low shared set. It writes a register and reads it back in the same cycle; a bypassed write port would return the new value a cycle early. It pushes the count of windows in use to both ends. A counter that saturates in the wrong place would raise the flags one call or return late or early, or would stop the pointer. The bench also combines a write with a call, and asserts call and return together. These two cases catch a block that picks the wrong window for the write, or that lets one strobe win.

// File: rtl/regwin_pkg.sv
// Shared definitions for the overlapped register window file.
// Assumes: every module of the block imports this package.
package regwin_pkg;

    // Decoded window movement for one cycle.
    typedef enum logic [1:0] {
        WIN_HOLD = 2'd0,
        WIN_CALL = 2'd1,
        WIN_RET  = 2'd2
    } win_move_e;

    // Turn the two strobes into a single move; both together cancel.
    function automatic win_move_e decode_move(input logic call_s, input logic ret_s);
        if (call_s && !ret_s) return WIN_CALL;
        if (ret_s && !call_s) return WIN_RET;
        return WIN_HOLD;
    endfunction

endpackage

// File: rtl/regwin_map.sv
// Logical-to-physical register index translation.
// Globals map to themselves. Every other logical number lands in a
// circular region that begins after the globals; each window is offset by
// LOCALS+SHARED from the previous one, so the high shared set of a
// window coincides with the low shared set of the next.
// Assumes: lreg < GLOBALS + LOCALS + 2*SHARED and win < WINDOWS.
module regwin_map #(
    parameter int GLOBALS = 10,
    parameter int LOCALS  = 10,
    parameter int SHARED  = 6,
    parameter int WINDOWS = 4,
    parameter int LW      = 5,
    parameter int CW      = 2,
    parameter int PW      = 7
) (
    input  logic [LW-1:0] lreg,
    input  logic [CW-1:0] win,
    output logic [PW-1:0] preg
);
    localparam int STRIDE = LOCALS + SHARED;
    localparam int RING   = STRIDE * WINDOWS;

    int unsigned offs;

    // Compute the physical index for one logical number.
    always_comb begin
        offs = 0;
        if (int'(lreg) < GLOBALS) begin
            preg = PW'(lreg);
        end else begin
            offs = (int'(win) * STRIDE + int'(lreg) - GLOBALS) % RING;
            preg = PW'(GLOBALS + int'(offs));
        end
    end

endmodule

// File: rtl/regwin_ctrl.sv
// Window pointer and windows-in-use counter.
// A lone call advances the pointer, a lone return retreats it, both modulo
// WINDOWS; simultaneous strobes cancel. The in-use count saturates at
// WINDOWS (overflow) and at 1 (underflow); the pointer moves regardless.
// Assumes: synchronous active-low reset.
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int WINDOWS = 4,
    parameter int CW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [CW-1:0] cwp,
    output logic          ovf,
    output logic          unf
);
    localparam int RCW = $clog2(WINDOWS + 1);
    localparam logic [CW-1:0]  LAST_WIN = CW'(WINDOWS - 1);
    localparam logic [RCW-1:0] FULL     = RCW'(WINDOWS);
    localparam logic [RCW-1:0] ONE      = RCW'(1);

    win_move_e      move;
    logic [RCW-1:0] in_use;

    // Decode this cycle's move and the exception flags.
    always_comb begin
        move = decode_move(call_i, ret_i);
        ovf  = (move == WIN_CALL) && (in_use == FULL);
        unf  = (move == WIN_RET)  && (in_use == ONE);
    end

    // Update the pointer and the in-use count at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp    <= '0;
            in_use <= ONE;
        end else begin
            case (move)
                WIN_CALL: begin
                    cwp <= (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
                    if (in_use != FULL) in_use <= in_use + 1'b1;
                end
                WIN_RET: begin
                    cwp <= (cwp == '0) ? LAST_WIN : cwp - 1'b1;
                    if (in_use != ONE) in_use <= in_use - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_call_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i) |=> cwp == (($past(cwp) == LAST_WIN) ? '0 : $past(cwp) + 1'b1));
    assert_ret_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i) |=> cwp == (($past(cwp) == '0) ? LAST_WIN : $past(cwp) - 1'b1));
    assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp) && $stable(in_use));
    assert_ovf_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> in_use == FULL);
    assert_unf_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> in_use == ONE);
    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

endmodule

// File: rtl/regwin_store.sv
// Physical register storage: one write port at the clock edge and NRD
// combinational read ports. A read of the entry being written returns its
// pre-edge value. Reset clears every entry.
// Assumes: addresses come from the mapper and lie below ENTRIES.
module regwin_store #(
    parameter int DW      = 32,
    parameter int ENTRIES = 74,
    parameter int PW      = 7,
    parameter int NRD     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    logic [DW-1:0] mem [ENTRIES];

    // Clear on reset, otherwise commit the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < ENTRIES)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Select the addressed entry for this read port.
        always_comb begin
            rdata[p] = (int'(raddr[p]) < ENTRIES) ? mem[raddr[p]] : '0;
        end
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/regwin_file.sv
// Top of the overlapped register window file: three mappers (two reads,
// one write) translate logical numbers through the current window, the
// store holds the physical registers and the control tracks the window.
// Assumes: synchronous active-low reset; the write uses the window current
// before the edge.
module regwin_file #(
    parameter int DW      = 32,
    parameter int GLOBALS = 10,
    parameter int LOCALS  = 10,
    parameter int SHARED  = 6,
    parameter int WINDOWS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [4:0]    rd_addr_b,
    output logic [DW-1:0] rd_data_b,
    input  logic          wr_en,
    input  logic [4:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [1:0]    cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam int ENTRIES = (LOCALS + SHARED) * WINDOWS + GLOBALS;
    localparam int LW      = 5;
    localparam int CW      = 2;
    localparam int PW      = $clog2(ENTRIES);
    localparam int NRD     = 2;
    localparam int NMAP    = NRD + 1;

    logic [LW-1:0] laddr [NMAP];
    logic [PW-1:0] paddr [NMAP];
    logic [PW-1:0] rd_paddr [NRD];
    logic [DW-1:0] rd_word [NRD];
    logic [CW-1:0] cwp;

    // Gather the logical addresses and spread the physical ones.
    always_comb begin
        laddr[0] = rd_addr_a;
        laddr[1] = rd_addr_b;
        laddr[2] = wr_addr;
        for (int i = 0; i < NRD; i++) rd_paddr[i] = paddr[i];
        rd_data_a = rd_word[0];
        rd_data_b = rd_word[1];
        cwp_o     = cwp;
    end

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        regwin_map #(
            .GLOBALS(GLOBALS), .LOCALS(LOCALS), .SHARED(SHARED),
            .WINDOWS(WINDOWS), .LW(LW), .CW(CW), .PW(PW)
        ) u_map (
            .lreg(laddr[m]),
            .win (cwp),
            .preg(paddr[m])
        );
    end

    regwin_store #(.DW(DW), .ENTRIES(ENTRIES), .PW(PW), .NRD(NRD)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(paddr[NRD]),
        .wdata(wr_data),
        .raddr(rd_paddr),
        .rdata(rd_word)
    );

    regwin_ctrl #(.WINDOWS(WINDOWS), .CW(CW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .call_i(call_i),
        .ret_i (ret_i),
        .cwp   (cwp),
        .ovf   (ovf_o),
        .unf   (unf_o)
    );

    assert_map_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(paddr[NRD]) < ENTRIES && int'(paddr[0]) < ENTRIES && int'(paddr[1]) < ENTRIES);
    assert_globals_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a < 5'(GLOBALS)) |-> paddr[0] == PW'(rd_addr_a));

endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;

    typedef struct {
        int          sel;   // 0 rd_a, 1 rd_b, 2 cwp, 3 ovf, 4 unf
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic [1:0]  cwp_o;
    logic        ovf_o, unf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    item_t       sb[$];
    logic [31:0] mdl [74];
    int          m_cwp, m_use;

    always #4 clk = ~clk;

    regwin_file uut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // Physical slot behind a logical number, written from the window rules.
    function automatic int slot(input int w, input int l);
        if (l < 10) return l;
        return 10 + ((w * 16 + (l - 10)) % 64);
    endfunction

    function automatic void push(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endfunction

    // Driver: apply one cycle of stimulus, queue expectations, advance model.
    task automatic step(input bit c, input bit r, input bit we, input int wa,
                        input logic [31:0] wd, input int ra, input int rb,
                        input string tag);
        bit lone_c, lone_r;
        rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        call_i = c; ret_i = r;
        lone_c = c && !r;
        lone_r = r && !c;
        push(0, mdl[slot(m_cwp, ra)], tag);
        push(1, mdl[slot(m_cwp, rb)], tag);
        push(2, 32'(m_cwp), tag);
        push(3, 32'(lone_c && m_use == 4), tag);
        push(4, 32'(lone_r && m_use == 1), tag);
        @(posedge clk);
        #1;
        if (we) mdl[slot(m_cwp, wa)] = wd;
        if (lone_c) begin m_cwp = (m_cwp + 1) % 4; if (m_use < 4) m_use++; end
        if (lone_r) begin m_cwp = (m_cwp + 3) % 4; if (m_use > 1) m_use--; end
        call_i = 1'b0; ret_i = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: compare queued expectations mid-cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                0: act = rd_data_a;
                1: act = rd_data_b;
                2: act = 32'(cwp_o);
                3: act = 32'(ovf_o);
                default: act = 32'(unf_o);
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    initial begin
        for (int i = 0; i < 74; i++) mdl[i] = '0;
        m_cwp = 0; m_use = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state over all logical numbers
        for (int l = 0; l < 32; l += 2) step(0, 0, 0, 0, 0, l, l + 1, "R1 reset");
        // R8: fill window 0 with distinct data, read with both ports
        for (int l = 0; l < 32; l++) step(0, 0, 1, l, 32'hA000_0000 + l, l, 31 - l, "R8 fill");
        // R3: same-cycle read returns old value, then the new one
        step(0, 0, 1, 20, 32'h1234_5678, 20, 20, "R3 old on write");
        step(0, 0, 0, 0, 0, 20, 5, "R3 new after write");
        // R2 and R5: globals and shared set seen from window 1
        step(1, 0, 0, 0, 0, 3, 26, "R4 call");
        for (int l = 10; l < 16; l++) step(0, 0, 0, 0, 0, l, l - 7, "R5 R2 callee view");
        // R6: locals private
        step(0, 0, 1, 20, 32'hBEEF_0001, 20, 16, "R6 write local w1");
        step(0, 0, 1, 12, 32'hC0DE_0012, 12, 9, "R5 callee writes shared");
        step(0, 0, 0, 0, 0, 20, 12, "R6 read w1");
        step(0, 1, 0, 0, 0, 20, 28, "R4 ret");
        step(0, 0, 0, 0, 0, 20, 28, "R6 R5 caller sees");
        // R9 and R7: go round the ring and overflow
        step(1, 0, 0, 0, 0, 0, 1, "R4 call to w1");
        step(1, 0, 0, 0, 0, 0, 1, "R4 call to w2");
        step(1, 0, 0, 0, 0, 0, 1, "R4 call to w3");
        step(0, 0, 1, 29, 32'h7777_0029, 29, 18, "R7 write high shared w3");
        step(1, 0, 0, 0, 0, 29, 30, "R9 overflow call");
        step(0, 0, 0, 0, 0, 13, 29, "R7 wrap view w0");
        step(1, 0, 0, 0, 0, 0, 0, "R9 overflow again");
        // R10: unwind to underflow
        for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 0, 17, 27, "R10 unwind");
        step(0, 1, 0, 0, 0, 17, 27, "R10 underflow ret");
        step(0, 1, 0, 0, 0, 17, 27, "R10 underflow repeat");
        // R11: both strobes cancel
        step(1, 1, 0, 0, 0, 17, 27, "R11 both");
        step(1, 1, 0, 0, 0, 17, 27, "R11 both hold");
        // R12: write in the call cycle lands in the old window
        step(1, 0, 1, 22, 32'h5555_0022, 22, 27, "R12 write with call");
        step(0, 0, 0, 0, 0, 22, 11, "R12 new window");
        step(0, 1, 1, 16, 32'h6666_0016, 16, 22, "R12 write with ret");
        step(0, 0, 0, 0, 0, 22, 16, "R12 back in old");
        step(1, 0, 0, 0, 0, 16, 22, "R12 return fwd");
        step(0, 0, 0, 0, 0, 16, 22, "R12 check fwd");
        @(negedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule